// File: doc/BRIEF.md
# SPI Controller Interrupt Status Unit

This block holds the interrupt event register and the interrupt mask of a multichannel SPI master with up to four channels, and drives the single interrupt request of that master. Each channel raises two events: transmit-empty and receive-full. A third event, word-count-done, is present only on the newer revision. A channel's events are sampled on a one-cycle check strobe from the channel logic. At that moment the block qualifies the strobe with the channel's ready flags, its transfer mode and its turbo setting. When the channel owns the shared FIFO, it also compares the FIFO fill level against the 6-bit threshold.

Software reaches the block through a plain 32-bit register port with separate write and read strobes. Reads return data one cycle after the strobe. The event register is cleared by writing ones. A module test mode, combined with a force bit in the test register, fills the event register with every implemented bit. While both of those bits are set, software clears are locked out. A reset command written through the same port restores the register defaults. The port has no back-pressure, because every access completes in one cycle.

Top module: `mcspi_irq_unit`

## Requirements
- R1: Status bit positions: a channel check strobe sets bit 4n for transmit-empty and bit 4n+2 for receive-full of channel n. A word-count-done pulse sets bit 17, but only when NEW_REV=1.
- R2: `irq` is high exactly when at least one status bit is set together with its enable bit.
- R3: A write to address 0 (status) clears each status bit written as 1 and leaves the others unchanged.
- R4: A status write has no effect while control bit 3 and test bit 11 are both set.
- R5: The enable register (address 1) keeps only the bits of mask 0x3777F when NEW_REV=1, and only the bits of mask 0x1777F when NEW_REV=0.
- R6: Either of two writes ORs the revision mask into status: a control write (address 2) with bit 3 set while test bit 11 is set, or a test write (address 3) with bit 11 set while control bit 3 is set.
- R7: Receive-full is set only when all of these hold: receive-ready is high, the mode is not 2'b10 (transmit-only), and turbo is low. If the channel owns the FIFO and receive FIFO use is on, the receive level must also be at or above the almost-full threshold.
- R8: Transmit-empty is set only when transmit-ready is high and the mode is not 2'b01 (receive-only). If the channel owns the FIFO and transmit FIFO use is on, the transmit level must also be at or below the almost-empty threshold.
- R9: Writing address 4 with bit 1 set clears status, enable and the 12-bit test register, and loads the 4-bit control register with 4. Hardware reset does the same.
- R10: When an event sets a bit in the same cycle that software clears it, the bit ends up set.
- R11: `reg_rdata` shows the addressed register one cycle after `reg_rd`. Address 4 and unused addresses read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ch_check | input | NUM_CH | Per-channel event evaluation strobe |
| ch_rx_ready | input | NUM_CH | Per-channel receive data ready flag |
| ch_tx_ready | input | NUM_CH | Per-channel transmit register ready flag |
| ch_mode | input | 2*NUM_CH | Per-channel transfer mode, 2 bits each (01 receive-only, 10 transmit-only) |
| ch_turbo | input | NUM_CH | Per-channel turbo setting |
| fifo_owner_vld | input | 1 | A channel owns the FIFO |
| fifo_owner_ch | input | CH_IDX_W | Index of the owning channel |
| rx_fifo_en | input | 1 | Owner uses the receive FIFO |
| tx_fifo_en | input | 1 | Owner uses the transmit FIFO |
| rx_level | input | LVL_W | Receive FIFO fill level |
| tx_level | input | LVL_W | Transmit FIFO fill level |
| rx_afull_thr | input | LVL_W | Receive almost-full threshold |
| tx_aempty_thr | input | LVL_W | Transmit almost-empty threshold |
| wcnt_done | input | 1 | Word-count-done pulse |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, one cycle after the strobe |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench builds two instances that share one register bus. The main one uses NUM_CH=4 and NEW_REV=1, which puts all four channels' bit positions, the FIFO ownership comparison on every index, and the word-count bit within reach. A second instance with NUM_CH=2 and NEW_REV=0 exposes the narrower enable mask, the absent word-count event, and the older force pattern. A table of channel-condition vectors covers the mode, turbo and threshold gating, and directed steps cover the test-mode lock and the set-versus-clear race.

// File: rtl/mcspi_irq_pkg.sv
package mcspi_irq_pkg;
  localparam int DATA_W   = 32;
  localparam int ADDR_W   = 3;
  localparam int CTRL_W   = 4;
  localparam int TEST_W   = 12;

  localparam logic [DATA_W-1:0] MASK_NEW = 32'h0003_777F;
  localparam logic [DATA_W-1:0] MASK_OLD = 32'h0001_777F;
  localparam logic [CTRL_W-1:0] CTRL_RST = 4'h4;

  localparam int WCNT_BIT   = 17;
  localparam int CTRL_TST_B = 3;
  localparam int TEST_FRC_B = 11;
  localparam int SRST_B     = 1;

  typedef enum logic [ADDR_W-1:0] {
    A_STATUS = 3'd0,
    A_ENABLE = 3'd1,
    A_CTRL   = 3'd2,
    A_TEST   = 3'd3,
    A_RESET  = 3'd4
  } reg_addr_e;

  typedef enum logic [1:0] {
    XM_BOTH    = 2'b00,
    XM_RX_ONLY = 2'b01,
    XM_TX_ONLY = 2'b10,
    XM_RSVD    = 2'b11
  } xfer_mode_e;

  function automatic logic [DATA_W-1:0] rev_mask(input bit new_rev);
    return new_rev ? MASK_NEW : MASK_OLD;
  endfunction
endpackage

// File: rtl/mcspi_irq_evt.sv
module mcspi_irq_evt
  import mcspi_irq_pkg::*;
#(
  parameter int LVL_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             check,
  input  logic             rx_ready,
  input  logic             tx_ready,
  input  logic [1:0]       mode,
  input  logic             turbo,
  input  logic             owns,
  input  logic             rx_fifo_en,
  input  logic             tx_fifo_en,
  input  logic [LVL_W-1:0] rx_level,
  input  logic [LVL_W-1:0] tx_level,
  input  logic [LVL_W-1:0] rx_afull_thr,
  input  logic [LVL_W-1:0] tx_aempty_thr,
  output logic             rx_set,
  output logic             tx_set
);
  logic rx_lvl_ok, tx_lvl_ok;

  // FIFO threshold only matters for the channel that owns the FIFO
  assign rx_lvl_ok = !(owns && rx_fifo_en) || (rx_level >= rx_afull_thr);
  assign tx_lvl_ok = !(owns && tx_fifo_en) || (tx_level <= tx_aempty_thr);

  assign rx_set = check && rx_ready && (mode != XM_TX_ONLY) && !turbo && rx_lvl_ok;
  assign tx_set = check && tx_ready && (mode != XM_RX_ONLY) && tx_lvl_ok;

  // R7: turbo suppresses receive-full
  p_turbo_blocks_rx_r7: assert property (@(posedge clk) disable iff (!rst_n)
    turbo |-> !rx_set);
  // R8: receive-only mode never raises transmit-empty
  p_rxonly_blocks_tx_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == XM_RX_ONLY) |-> !tx_set);
endmodule

// File: rtl/mcspi_irq_regs.sv
module mcspi_irq_regs
  import mcspi_irq_pkg::*;
#(
  parameter bit NEW_REV = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] set_vec,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic [DATA_W-1:0] status_q,
  output logic [DATA_W-1:0] enable_q
);
  localparam logic [DATA_W-1:0] MASK = rev_mask(NEW_REV);

  logic [CTRL_W-1:0] ctrl_q;
  logic [TEST_W-1:0] test_q;
  logic              wr_stat, wr_en, wr_ctrl, wr_test, srst, lock, force_all;
  logic [DATA_W-1:0] clr_vec, status_d;

  assign wr_stat = reg_wr && (reg_addr == A_STATUS);
  assign wr_en   = reg_wr && (reg_addr == A_ENABLE);
  assign wr_ctrl = reg_wr && (reg_addr == A_CTRL);
  assign wr_test = reg_wr && (reg_addr == A_TEST);
  assign srst    = reg_wr && (reg_addr == A_RESET) && reg_wdata[SRST_B];
  assign lock    = ctrl_q[CTRL_TST_B] && test_q[TEST_FRC_B];

  assign force_all = (wr_ctrl && reg_wdata[CTRL_TST_B] && test_q[TEST_FRC_B]) ||
                     (wr_test && reg_wdata[TEST_FRC_B] && ctrl_q[CTRL_TST_B]);

  assign clr_vec  = (wr_stat && !lock) ? reg_wdata : '0;
  // set and force are ORed after the clear, so they win a same-cycle race
  assign status_d = (status_q & ~clr_vec) | (set_vec & MASK) | (force_all ? MASK : '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
      enable_q <= '0;
      ctrl_q   <= CTRL_RST;
      test_q   <= '0;
    end else if (srst) begin
      status_q <= '0;
      enable_q <= '0;
      ctrl_q   <= CTRL_RST;
      test_q   <= '0;
    end else begin
      status_q <= status_d;
      if (wr_en)   enable_q <= reg_wdata & MASK;
      if (wr_ctrl) ctrl_q   <= reg_wdata[CTRL_W-1:0];
      if (wr_test) test_q   <= reg_wdata[TEST_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_rdata <= '0;
    end else if (reg_rd) begin
      unique case (reg_addr)
        A_STATUS: reg_rdata <= status_q;
        A_ENABLE: reg_rdata <= enable_q;
        A_CTRL:   reg_rdata <= {{(DATA_W-CTRL_W){1'b0}}, ctrl_q};
        A_TEST:   reg_rdata <= {{(DATA_W-TEST_W){1'b0}}, test_q};
        default:  reg_rdata <= '0;
      endcase
    end
  end

  // R9: reset command restores defaults
  p_soft_reset_r9: assert property (@(posedge clk) disable iff (!rst_n)
    srst |=> (status_q == '0) && (enable_q == '0) && (ctrl_q == CTRL_RST));
  // R3: unlocked clear removes written-one bits not being set again
  p_w1c_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat && !lock && !srst && !force_all) |=>
      ((status_q & $past(reg_wdata & ~set_vec)) == '0));
  // R4: locked clear leaves every set bit in place
  p_lock_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat && lock && !srst) |=> ((status_q & $past(status_q)) == $past(status_q)));
  // R10: an event bit is present after its set cycle
  p_set_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ((|(set_vec & MASK)) && !srst) |=>
      ((status_q & $past(set_vec & MASK)) == $past(set_vec & MASK)));
  // R11: status read returns the value held at the strobe
  p_read_lat_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && (reg_addr == A_STATUS)) |=> (reg_rdata == $past(status_q)));
endmodule

// File: rtl/mcspi_irq_unit.sv
module mcspi_irq_unit
  import mcspi_irq_pkg::*;
#(
  parameter int  NUM_CH  = 4,
  parameter bit  NEW_REV = 1'b1,
  parameter int  LVL_W   = 6,
  localparam int CH_IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_CH-1:0]     ch_check,
  input  logic [NUM_CH-1:0]     ch_rx_ready,
  input  logic [NUM_CH-1:0]     ch_tx_ready,
  input  logic [2*NUM_CH-1:0]   ch_mode,
  input  logic [NUM_CH-1:0]     ch_turbo,
  input  logic                  fifo_owner_vld,
  input  logic [CH_IDX_W-1:0]   fifo_owner_ch,
  input  logic                  rx_fifo_en,
  input  logic                  tx_fifo_en,
  input  logic [LVL_W-1:0]      rx_level,
  input  logic [LVL_W-1:0]      tx_level,
  input  logic [LVL_W-1:0]      rx_afull_thr,
  input  logic [LVL_W-1:0]      tx_aempty_thr,
  input  logic                  wcnt_done,
  input  logic                  reg_wr,
  input  logic                  reg_rd,
  input  logic [ADDR_W-1:0]     reg_addr,
  input  logic [DATA_W-1:0]     reg_wdata,
  output logic [DATA_W-1:0]     reg_rdata,
  output logic                  irq
);
  logic [NUM_CH-1:0] rx_set, tx_set;
  logic [DATA_W-1:0] set_vec, status_q, enable_q;

  for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
    logic owns;
    assign owns = fifo_owner_vld && (fifo_owner_ch == CH_IDX_W'(n));

    mcspi_irq_evt #(.LVL_W(LVL_W)) u_evt (
      .clk           (clk),
      .rst_n         (rst_n),
      .check         (ch_check[n]),
      .rx_ready      (ch_rx_ready[n]),
      .tx_ready      (ch_tx_ready[n]),
      .mode          (ch_mode[2*n +: 2]),
      .turbo         (ch_turbo[n]),
      .owns          (owns),
      .rx_fifo_en    (rx_fifo_en),
      .tx_fifo_en    (tx_fifo_en),
      .rx_level      (rx_level),
      .tx_level      (tx_level),
      .rx_afull_thr  (rx_afull_thr),
      .tx_aempty_thr (tx_aempty_thr),
      .rx_set        (rx_set[n]),
      .tx_set        (tx_set[n])
    );
  end

  always_comb begin
    set_vec = '0;
    for (int n = 0; n < NUM_CH; n++) begin
      set_vec[4*n]     = tx_set[n];
      set_vec[4*n + 2] = rx_set[n];
    end
    if (NEW_REV) set_vec[WCNT_BIT] = wcnt_done;
  end

  mcspi_irq_regs #(.NEW_REV(NEW_REV)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_vec   (set_vec),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .status_q  (status_q),
    .enable_q  (enable_q)
  );

  assign irq = |(status_q & enable_q);

  // R2: no request while the mask is empty
  p_irq_masked_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (enable_q == '0) |-> !irq);
endmodule

// File: tb/mcspi_irq_unit_tb_top.sv
`timescale 1ns/1ps
module mcspi_irq_unit_tb_top;
  localparam int NCH = 4;
  localparam int LW  = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [NCH-1:0]   ch_check = '0, ch_rx_ready = '0, ch_tx_ready = '0, ch_turbo = '0;
  logic [2*NCH-1:0] ch_mode = '0;
  logic             own_vld = 1'b0, rx_fe = 1'b0, tx_fe = 1'b0, wcnt_done = 1'b0;
  logic [1:0]       own_ch = '0;
  logic [LW-1:0]    rx_lvl = '0, tx_lvl = '0;
  logic [LW-1:0]    afull = 6'd8, aempty = 6'd4;
  logic             reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0]       reg_addr = '0;
  logic [31:0]      reg_wdata = '0;
  logic [31:0]      rdata, rdata_o;
  logic             irq, irq_o;

  mcspi_irq_unit #(.NUM_CH(NCH), .NEW_REV(1'b1), .LVL_W(LW)) dut_i (
    .clk(clk), .rst_n(rst_n), .ch_check(ch_check), .ch_rx_ready(ch_rx_ready),
    .ch_tx_ready(ch_tx_ready), .ch_mode(ch_mode), .ch_turbo(ch_turbo),
    .fifo_owner_vld(own_vld), .fifo_owner_ch(own_ch), .rx_fifo_en(rx_fe),
    .tx_fifo_en(tx_fe), .rx_level(rx_lvl), .tx_level(tx_lvl),
    .rx_afull_thr(afull), .tx_aempty_thr(aempty), .wcnt_done(wcnt_done),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(rdata), .irq(irq));

  mcspi_irq_unit #(.NUM_CH(2), .NEW_REV(1'b0), .LVL_W(LW)) dut_old_i (
    .clk(clk), .rst_n(rst_n), .ch_check(2'b00), .ch_rx_ready(2'b00),
    .ch_tx_ready(2'b00), .ch_mode(4'b0000), .ch_turbo(2'b00),
    .fifo_owner_vld(1'b0), .fifo_owner_ch(1'b0), .rx_fifo_en(1'b0),
    .tx_fifo_en(1'b0), .rx_level(rx_lvl), .tx_level(tx_lvl),
    .rx_afull_thr(afull), .tx_aempty_thr(aempty), .wcnt_done(wcnt_done),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(rdata_o), .irq(irq_o));

  int n_tests = 0, n_fail = 0;
  bit done = 1'b0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  // vector: ch, rxr, txr, mode, turbo, own, rxfe, txfe, rxlvl, txlvl, exp_rx, exp_tx
  function automatic logic [27:0] mk(input int c, input bit rr, input bit tr,
      input logic [1:0] m, input bit tb, input bit ow, input bit rf, input bit tf,
      input int rl, input int tl, input bit er, input bit et);
    return {2'(c), rr, tr, m, tb, ow, rf, tf, 6'(rl), 6'(tl), 4'b0, er, et};
  endfunction

  localparam int NV = 12;
  localparam logic [27:0] VEC [NV] = '{
    mk(0, 1, 1, 2'b00, 0, 0, 0, 0,  0,  0, 1, 1),
    mk(1, 1, 0, 2'b00, 0, 0, 0, 0,  0,  0, 1, 0),
    mk(2, 0, 1, 2'b00, 0, 0, 0, 0,  0,  0, 0, 1),
    mk(3, 1, 1, 2'b10, 0, 0, 0, 0,  0,  0, 0, 1),
    mk(0, 1, 1, 2'b01, 0, 0, 0, 0,  0,  0, 1, 0),
    mk(1, 1, 1, 2'b00, 1, 0, 0, 0,  0,  0, 0, 1),
    mk(2, 1, 1, 2'b00, 0, 1, 1, 0,  7,  0, 0, 1),
    mk(2, 1, 1, 2'b00, 0, 1, 1, 0,  8,  0, 1, 1),
    mk(3, 1, 1, 2'b00, 0, 1, 0, 1,  0,  4, 1, 1),
    mk(3, 1, 1, 2'b00, 0, 1, 0, 1,  0,  5, 1, 0),
    mk(0, 1, 1, 2'b00, 0, 0, 1, 1,  0, 63, 1, 1),
    mk(1, 1, 1, 2'b00, 0, 1, 1, 1, 63,  0, 1, 1)
  };

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // reset state (R9)
    rd(3'd0); chk("R9 reset status", rdata, 32'h0);
    rd(3'd1); chk("R9 reset enable", rdata, 32'h0);
    rd(3'd2); chk("R9 reset control", rdata, 32'h4);
    rd(3'd3); chk("R9 reset test", rdata, 32'h0);
    chk("R2 reset irq", {31'b0, irq}, 32'h0);

    // table walk: R1 bit positions, R7 and R8 gating
    for (int i = 0; i < NV; i++) begin
      logic [27:0] v;
      int c;
      logic [31:0] exp;
      v = VEC[i];
      c = int'(v[27:26]);
      wr(3'd0, 32'hFFFF_FFFF);
      @(negedge clk);
      ch_rx_ready = '0; ch_tx_ready = '0; ch_turbo = '0; ch_mode = '0;
      ch_rx_ready[c] = v[25]; ch_tx_ready[c] = v[24];
      ch_mode[2*c +: 2] = v[23:22]; ch_turbo[c] = v[21];
      own_vld = 1'b1; own_ch = v[20] ? 2'(c) : 2'(c + 1);
      rx_fe = v[19]; tx_fe = v[18]; rx_lvl = v[17:12]; tx_lvl = v[11:6];
      ch_check[c] = 1'b1;
      @(negedge clk);
      ch_check = '0;
      exp = '0;
      exp[4*c + 2] = v[1];
      exp[4*c]     = v[0];
      rd(3'd0);
      chk($sformatf("R1 R7 R8 vector %0d", i), rdata, exp);
    end
    own_vld = 1'b0; rx_fe = 1'b0; tx_fe = 1'b0;
    ch_rx_ready = '0; ch_tx_ready = '0; ch_mode = '0; ch_turbo = '0;
    wr(3'd0, 32'hFFFF_FFFF);

    // R1 word-count bit, absent on older revision
    @(negedge clk); wcnt_done = 1'b1;
    @(negedge clk); wcnt_done = 1'b0;
    rd(3'd0);
    chk("R1 word-count bit 17", rdata, 32'h0002_0000);
    chk("R1 no word-count on old rev", rdata_o, 32'h0);

    // R3 partial clear
    @(negedge clk); ch_tx_ready[0] = 1'b1; ch_rx_ready[0] = 1'b1; ch_check[0] = 1'b1;
    @(negedge clk); ch_check = '0;
    wr(3'd0, 32'h0002_0001);
    rd(3'd0); chk("R3 write-one clears only written bits", rdata, 32'h4);

    // R2 interrupt combine
    chk("R2 irq low with empty mask", {31'b0, irq}, 32'h0);
    wr(3'd1, 32'h1);
    chk("R2 irq low, enabled bit not pending", {31'b0, irq}, 32'h0);
    wr(3'd1, 32'h4);
    chk("R2 irq high on enabled pending bit", {31'b0, irq}, 32'h1);

    // R10 set beats clear
    @(negedge clk);
    ch_check[0] = 1'b1; ch_rx_ready[0] = 1'b0;
    reg_wr = 1'b1; reg_addr = 3'd0; reg_wdata = 32'h5;
    @(negedge clk);
    ch_check = '0; reg_wr = 1'b0;
    rd(3'd0); chk("R10 set wins over same-cycle clear", rdata, 32'h1);
    ch_tx_ready = '0;

    // R5 enable mask per revision
    wr(3'd1, 32'hFFFF_FFFF);
    rd(3'd1);
    chk("R5 enable mask new rev", rdata, 32'h0003_777F);
    chk("R5 enable mask old rev", rdata_o, 32'h0001_777F);
    wr(3'd1, 32'h0);
    wr(3'd0, 32'hFFFF_FFFF);

    // R6 force via control write while force bit already set
    wr(3'd3, 32'h800);
    rd(3'd0); chk("R6 force bit alone does nothing", rdata, 32'h0);
    wr(3'd2, 32'hC);
    rd(3'd0);
    chk("R6 force via control new rev", rdata, 32'h0003_777F);
    chk("R6 force via control old rev", rdata_o, 32'h0001_777F);

    // R4 locked clear
    wr(3'd0, 32'hFFFF_FFFF);
    rd(3'd0); chk("R4 clear ignored while locked", rdata, 32'h0003_777F);

    // unlock, clear, then force via test write
    wr(3'd3, 32'h0);
    wr(3'd0, 32'hFFFF_FFFF);
    rd(3'd0); chk("R3 clear after unlock", rdata, 32'h0);
    wr(3'd3, 32'h800);
    rd(3'd0); chk("R6 force via test write", rdata, 32'h0003_777F);

    // R9 reset command
    wr(3'd1, 32'h3);
    wr(3'd4, 32'h2);
    rd(3'd0); chk("R9 soft reset status", rdata, 32'h0);
    rd(3'd1); chk("R9 soft reset enable", rdata, 32'h0);
    rd(3'd2); chk("R9 soft reset control", rdata, 32'h4);
    rd(3'd3); chk("R9 soft reset test", rdata, 32'h0);

    // R11 read latency and unused address
    wr(3'd1, 32'h10);
    @(negedge clk); reg_rd = 1'b1; reg_addr = 3'd1;
    @(negedge clk); reg_rd = 1'b0;
    chk("R11 data one cycle after strobe", rdata, 32'h10);
    rd(3'd6); chk("R11 unused address reads zero", rdata, 32'h0);
    rd(3'd4); chk("R11 reset address reads zero", rdata, 32'h0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule